// File: doc/BRIEF.md
# Serial Flash Command Buffer Engine

This block is a register-driven serial master for flash memories. Software writes a whole command into a 128-byte shared buffer through a 32-bit register bus. The command is the opcode, the address, any dummy bytes and any write payload. Software then sets an output byte count and an input byte count, and starts the engine by writing the enable and trigger bits to the control register in one write. The engine sends the output bytes on one data line in SPI mode 0. It then clocks in the requested input bytes and stores them in the same buffer, directly after the bytes it sent. Software copies the reply out of the buffer.

The serial clock has no divider. Each bit takes two core clocks. Chip select stays low for the whole transaction. After chip select goes high, the engine holds it high for a programmable minimum number of cycles. A programmable latch latency delays the sampling of the input line, which covers the round-trip delay through the pads. A soft-reset bit aborts any transfer. While it is set, the engine state readback shows idle.

Top module: `spi_cmdbuf_engine`

## Requirements
- R1: The buffer is read and written as 32-bit words at word addresses 0x40 to 0x5F. Byte n sits in word n/4, and byte 0 of each word is in bits 7:0.
- R2: Output bytes are sent from buffer offset 0 upward, most significant bit first. The serial clock idles low. MOSI changes only while the clock is low. Each bit lasts exactly two core clocks.
- R3: Input bytes are assembled most significant bit first. They are stored from buffer offset out_len upward, where out_len is the output byte count.
- R4: The control register is at word address 0. Its bits are: bit 4 extended-I/O select (readback only), bit 3 enable, bit 2 trigger (reads 0), bit 1 ready, bit 0 busy. The output count is at address 1 and the input count at address 2. A transaction starts only when one write sets enable and trigger together. A trigger written without enable is ignored.
- R5: After an accepted trigger, ready becomes 1 while busy is still 1. Busy clears once the last input byte is stored. Ready stays 1 until software writes the control register with enable 0 while busy is 0.
- R6: A trigger written while busy is 1 is ignored. The running transfer is unaffected.
- R7: A trigger with both counts zero completes, with ready 1 and busy 0, without ever driving chip select low.
- R8: A trigger is ignored when out_len + in_len exceeds 128.
- R9: Chip select is low for exactly 2 × 8 × (out_len + in_len) core clocks. After it goes high, it stays high for at least the programmed deselect count before the next transaction.
- R10: With latch latency L (0 to 3), each input bit is sampled L core clocks after the end of the serial clock high phase.
- R11: The miscellaneous register is at address 3. Its fields are: bit 28 soft reset, bits 26:25 read latency (readback only), bits 9:8 latch latency, bits 4:0 deselect cycles. While soft reset is 1, the transfer is aborted, chip select is high, ready and busy are 0, and the state field (bits 3:0 of the status register at address 4) reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the serial bit clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 7 | Word address; bit 6 selects the buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions check the following on every cycle:
- the serial clock stays low while chip select is high;
- MOSI holds still while the clock is high;
- chip select is low only while busy is 1;
- ready is already set when busy falls;
- a start pulse never follows a busy cycle;
- the state readback is zero after a soft reset.

Some behaviour only the bench scenarios can show, because it needs data and counts:
- the bit order on the wire and where the reply lands in the buffer;
- the effect of the latch latency against a slow slave;
- the exact chip-select low time and the deselect gap;
- rejection of oversized and zero-length commands.

// File: rtl/spi_cmdbuf_pkg.sv
package spi_cmdbuf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_GAP   = 4'd1,
    ST_SHIFT = 4'd2,
    ST_DRAIN = 4'd3
  } eng_state_t;

  localparam int REG_CTL    = 0;
  localparam int REG_OUTLEN = 1;
  localparam int REG_INLEN  = 2;
  localparam int REG_MISC   = 3;
  localparam int REG_STAT   = 4;

  localparam int CTL_BUSY = 0;
  localparam int CTL_RDY  = 1;
  localparam int CTL_TRIG = 2;
  localparam int CTL_EN   = 3;
  localparam int CTL_XIO  = 4;

  localparam int MISC_SRST = 28;
endpackage

// File: rtl/spi_cmdbuf_mem.sv
module spi_cmdbuf_mem #(
  parameter int BYTES = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [$clog2(BYTES)-3:0] bus_word,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rword,
  input  logic                     eng_we,
  input  logic [$clog2(BYTES)-1:0] eng_widx,
  input  logic [7:0]               eng_wdata,
  input  logic [$clog2(BYTES)-1:0] eng_ridx,
  output logic [7:0]               eng_rbyte
);
  localparam int BIDX_W = $clog2(BYTES);
  localparam int WIDX_W = BIDX_W - 2;

  logic [7:0] mem [BYTES];

  // engine byte write wins over a bus word write to the same byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BYTES; b++) mem[b] <= '0;
    end else begin
      for (int b = 0; b < BYTES; b++) begin
        if (eng_we && eng_widx == BIDX_W'(b))
          mem[b] <= eng_wdata;
        else if (bus_we && bus_word == WIDX_W'(b / 4))
          mem[b] <= bus_wdata[8*(b%4) +: 8];
      end
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign bus_rword[8*l +: 8] = mem[{bus_word, 2'(l)}];
  end

  assign eng_rbyte = mem[eng_ridx];
endmodule

// File: rtl/spi_cmdbuf_shift.sv
module spi_cmdbuf_shift
  import spi_cmdbuf_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int BIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              start,
  input  logic [LEN_W-1:0]  out_len,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [1:0]        latch_lat,
  input  logic [4:0]        desel_cyc,
  input  logic [7:0]        tx_byte,
  output logic [BIDX_W-1:0] tx_idx,
  output logic              rx_we,
  output logic [BIDX_W-1:0] rx_idx,
  output logic [7:0]        rx_data,
  output logic              done,
  output logic [3:0]        state,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int CNT_W = LEN_W + 4;

  eng_state_t       st;
  logic [LEN_W-1:0] olen, ilen, rx_cnt;
  logic [CNT_W-1:0] bit_cnt, tot_bits, sel_bit;
  logic [LEN_W:0]   sel_byte, len_sum;
  logic             phase, sck_q, cs_q, mosi_q, done_q;
  logic [4:0]       gap;
  logic [2:0]       cap_pipe, rx_bits;
  logic [6:0]       rx_sh;
  logic             strobe, cap, last_bit, mosi_nxt;
  logic [LEN_W-1:0] rx_pos;

  assign len_sum  = {1'b0, out_len} + {1'b0, in_len};
  assign last_bit = (bit_cnt == tot_bits - CNT_W'(1));
  assign sel_bit  = (st == ST_SHIFT) ? bit_cnt + CNT_W'(1) : '0;
  assign sel_byte = sel_bit[CNT_W-1:3];
  assign tx_idx   = sel_byte[BIDX_W-1:0];
  assign mosi_nxt = (sel_byte < {1'b0, olen}) ? tx_byte[3'd7 - sel_bit[2:0]] : 1'b0;

  // capture point: end of the high phase of an input bit, delayed by latch_lat
  assign strobe = (st == ST_SHIFT) && phase && (bit_cnt[CNT_W-1:3] >= {1'b0, olen});
  assign cap    = (latch_lat == 2'd0) ? strobe : cap_pipe[latch_lat - 2'd1];

  assign rx_pos  = olen + rx_cnt;
  assign rx_idx  = rx_pos[BIDX_W-1:0];
  assign rx_we   = cap && (rx_bits == 3'd7);
  assign rx_data = {rx_sh, miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; olen <= '0; ilen <= '0; rx_cnt <= '0;
      bit_cnt <= '0; tot_bits <= '0; phase <= 1'b0;
      sck_q <= 1'b0; cs_q <= 1'b1; mosi_q <= 1'b0; done_q <= 1'b0;
      gap <= '0; cap_pipe <= '0; rx_bits <= '0; rx_sh <= '0;
    end else if (srst) begin
      st <= ST_IDLE; phase <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b1;
      mosi_q <= 1'b0; done_q <= 1'b0; gap <= '0; cap_pipe <= '0;
      rx_bits <= '0; rx_cnt <= '0;
    end else begin
      done_q   <= 1'b0;
      cap_pipe <= {cap_pipe[1:0], strobe};
      if (cap) begin
        rx_sh   <= {rx_sh[5:0], miso};
        rx_bits <= rx_bits + 3'd1;
        if (rx_bits == 3'd7) rx_cnt <= rx_cnt + LEN_W'(1);
      end
      if (cs_q && gap != 5'd0) gap <= gap - 5'd1;
      case (st)
        ST_IDLE: if (start) begin
          olen     <= out_len;
          ilen     <= in_len;
          tot_bits <= {len_sum, 3'b000};
          rx_cnt   <= '0;
          rx_bits  <= '0;
          if (len_sum == '0) done_q <= 1'b1;
          else               st     <= ST_GAP;
        end
        ST_GAP: if (gap == 5'd0) begin
          st      <= ST_SHIFT;
          cs_q    <= 1'b0;
          sck_q   <= 1'b0;
          phase   <= 1'b0;
          bit_cnt <= '0;
          mosi_q  <= mosi_nxt;
        end
        ST_SHIFT: begin
          if (!phase) begin
            sck_q <= 1'b1;
            phase <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            phase <= 1'b0;
            if (last_bit) begin
              st     <= ST_DRAIN;
              cs_q   <= 1'b1;
              gap    <= desel_cyc;
              mosi_q <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + CNT_W'(1);
              mosi_q  <= mosi_nxt;
            end
          end
        end
        ST_DRAIN: if (rx_cnt == ilen) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done  = done_q;
  assign state = st;
  assign sck   = sck_q;
  assign cs_n  = cs_q;
  assign mosi  = mosi_q;
endmodule

// File: rtl/spi_cmdbuf_engine.sv
module spi_cmdbuf_engine
  import spi_cmdbuf_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int BIDX_W = $clog2(BUF_BYTES);
  localparam int WIDX_W = BIDX_W - 2;
  localparam int LEN_W  = BIDX_W + 1;
  localparam int RIDX_W = ADDR_W - 1;

  logic              buf_sel;
  logic [RIDX_W-1:0] reg_idx;
  logic              wr_ctl, wr_olen, wr_ilen, wr_misc, len_ok, go;
  logic              ctl_en, ctl_xio, rdy, busy, start_q;
  logic [LEN_W-1:0]  out_len, in_len;
  logic              soft_rst;
  logic [1:0]        rd_lat, latch_lat;
  logic [4:0]        desel;
  logic [31:0]       buf_word;
  logic [BIDX_W-1:0] tx_idx, rx_idx;
  logic [7:0]        tx_byte, rx_data;
  logic              rx_we, eng_done;
  logic [3:0]        eng_state;

  assign buf_sel = bus_addr[ADDR_W-1];
  assign reg_idx = bus_addr[RIDX_W-1:0];
  assign wr_ctl  = bus_wr && !buf_sel && reg_idx == RIDX_W'(REG_CTL);
  assign wr_olen = bus_wr && !buf_sel && reg_idx == RIDX_W'(REG_OUTLEN);
  assign wr_ilen = bus_wr && !buf_sel && reg_idx == RIDX_W'(REG_INLEN);
  assign wr_misc = bus_wr && !buf_sel && reg_idx == RIDX_W'(REG_MISC);
  assign len_ok  = ({1'b0, out_len} + {1'b0, in_len}) <= (LEN_W+1)'(BUF_BYTES);
  assign go      = wr_ctl && bus_wdata[CTL_EN] && bus_wdata[CTL_TRIG]
                   && !busy && !soft_rst && len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_xio <= 1'b0; rdy <= 1'b0; busy <= 1'b0;
      start_q <= 1'b0; out_len <= '0; in_len <= '0; soft_rst <= 1'b0;
      rd_lat <= '0; latch_lat <= '0; desel <= '0;
    end else begin
      start_q <= go;
      if (wr_ctl) begin
        ctl_en  <= bus_wdata[CTL_EN];
        ctl_xio <= bus_wdata[CTL_XIO];
        if (!bus_wdata[CTL_EN] && !busy) rdy <= 1'b0;
      end
      if (go) begin
        busy <= 1'b1;
        rdy  <= 1'b0;
      end
      if (start_q)  rdy  <= 1'b1;
      if (eng_done) busy <= 1'b0;
      if (wr_olen) out_len <= bus_wdata[LEN_W-1:0];
      if (wr_ilen) in_len  <= bus_wdata[LEN_W-1:0];
      if (wr_misc) begin
        soft_rst  <= bus_wdata[MISC_SRST];
        rd_lat    <= bus_wdata[26:25];
        latch_lat <= bus_wdata[9:8];
        desel     <= bus_wdata[4:0];
      end
      if (soft_rst) begin
        busy    <= 1'b0;
        rdy     <= 1'b0;
        start_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (buf_sel) bus_rdata = buf_word;
    else begin
      case (reg_idx)
        RIDX_W'(REG_CTL):    bus_rdata = {27'd0, ctl_xio, ctl_en, 1'b0, rdy, busy};
        RIDX_W'(REG_OUTLEN): bus_rdata = 32'(out_len);
        RIDX_W'(REG_INLEN):  bus_rdata = 32'(in_len);
        RIDX_W'(REG_MISC):   bus_rdata = {3'd0, soft_rst, 1'b0, rd_lat, 15'd0,
                                          latch_lat, 3'd0, desel};
        RIDX_W'(REG_STAT):   bus_rdata = {28'd0, eng_state};
        default:             bus_rdata = '0;
      endcase
    end
  end

  spi_cmdbuf_mem #(.BYTES(BUF_BYTES)) i_mem (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_wr && buf_sel), .bus_word(bus_addr[WIDX_W-1:0]),
    .bus_wdata(bus_wdata), .bus_rword(buf_word),
    .eng_we(rx_we), .eng_widx(rx_idx), .eng_wdata(rx_data),
    .eng_ridx(tx_idx), .eng_rbyte(tx_byte)
  );

  spi_cmdbuf_shift #(.LEN_W(LEN_W), .BIDX_W(BIDX_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .start(start_q),
    .out_len(out_len), .in_len(in_len), .latch_lat(latch_lat),
    .desel_cyc(desel), .tx_byte(tx_byte), .tx_idx(tx_idx),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data),
    .done(eng_done), .state(eng_state),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/spi_cmdbuf_checker.sv
module spi_cmdbuf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rdy,
  input logic       soft_rst,
  input logic       start,
  input logic [3:0] state,
  input logic       cs_n,
  input logic       sck,
  input logic       mosi
);
  // R2: clock parked low whenever the device is deselected
  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2: data line holds during the high half of a bit
  p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && !cs_n) |-> $stable(mosi));

  // R9: chip select only inside a busy window
  p_cs_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R5: ready is up by the time busy drops (outside soft reset)
  p_ready_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !soft_rst) |-> rdy);

  // R6: a start never follows a busy cycle
  p_no_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !$past(busy));

  // R11: soft reset drives the state readback to idle
  p_srst_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state == 4'd0));
endmodule

bind spi_cmdbuf_engine spi_cmdbuf_checker i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rdy(rdy), .soft_rst(soft_rst),
  .start(start_q), .state(eng_state), .cs_n(spi_cs_n), .sck(spi_sck),
  .mosi(spi_mosi)
);

// File: tb/test_spi_cmdbuf_engine.sv
`timescale 1ns/1ps
module test_spi_cmdbuf_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_cmdbuf_engine i_spi_cmdbuf_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  localparam logic [6:0] A_CTL = 7'd0, A_OLEN = 7'd1, A_ILEN = 7'd2,
                         A_MISC = 7'd3, A_STAT = 7'd4, A_BUF = 7'h40;
  localparam logic [31:0] GO = 32'h0000_000C;

  // ---------------- monitors ----------------
  logic [63:0] mosi_sh = '0;
  int sck_total = 0, cs_falls = 0, hi_run = 0, lo_run = 0, last_gap = 0, last_low = 0;
  always @(posedge spi_sck) begin mosi_sh = {mosi_sh[62:0], spi_mosi}; sck_total++; end
  always @(negedge spi_cs_n) begin cs_falls++; last_gap = hi_run; end
  always @(posedge spi_cs_n) last_low = lo_run;
  always @(negedge clk) begin
    if (spi_cs_n) begin hi_run++; lo_run = 0; end
    else begin lo_run++; hi_run = 0; end
  end

  // ---------------- slave model (mode 0, delay in core clocks) ----------------
  int s_cnt = 0, s_olen = 0, s_dly = 0;
  logic [7:0] s_data [16];
  function automatic logic sbit(int k);
    if (k < s_olen * 8 || (k / 8 - s_olen) >= 16) return 1'b0;
    return s_data[k / 8 - s_olen][7 - (k % 8)];
  endfunction
  task automatic s_drive(int k);
    automatic logic v = sbit(k);
    automatic int d = s_dly * 10 + 1;
    fork begin #(d); spi_miso = v; end join_none
  endtask
  always @(negedge spi_cs_n) begin s_cnt = 0; s_drive(0); end
  always @(posedge spi_sck) s_cnt++;
  always @(negedge spi_sck) if (!spi_cs_n) s_drive(s_cnt);

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask
  task automatic wait_idle(string req);
    logic [31:0] v;
    int n = 0;
    do begin rd(A_CTL, v); n++; end while (v[0] && n < 3000);
    chk(!v[0], req, v, 0);
  endtask
  task automatic clr_mon();
    mosi_sh = '0; sck_total = 0; cs_falls = 0;
  endtask
  task automatic run(int ol, int il);
    wr(A_OLEN, ol); wr(A_ILEN, il); s_olen = ol; wr(A_CTL, GO);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R2 reset pins", {spi_cs_n, spi_sck}, 2'b10);
    rd(A_CTL, v);  chk(v == 0, "R4 ctl reset", v, 0);
    rd(A_STAT, v); chk(v == 0, "R11 state reset", v, 0);
  endtask

  task automatic t_buffer();
    logic [31:0] v;
    wr(A_BUF + 7'd5, 32'h4433_2211);
    wr(A_BUF + 7'd31, 32'hDEAD_BEEF);
    rd(A_BUF + 7'd5, v);  chk(v == 32'h4433_2211, "R1 word 5", v, 32'h4433_2211);
    rd(A_BUF + 7'd31, v); chk(v == 32'hDEAD_BEEF, "R1 word 31", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    logic [31:0] e = (32'd2 << 25) | (32'd1 << 8) | 32'd10;
    wr(A_MISC, e);
    rd(A_MISC, v); chk(v == e, "R11 misc fields", v, e);
    wr(A_CTL, 32'h10);
    rd(A_CTL, v); chk(v == 32'h10, "R4 xio readback", v, 32'h10);
    wr(A_CTL, 0);
  endtask

  task automatic t_trig_noen();
    logic [31:0] v;
    clr_mon(); wr(A_OLEN, 2); wr(A_ILEN, 0);
    wr(A_CTL, 32'h4);
    rd(A_CTL, v); chk(v[1:0] == 2'b00, "R4 trigger without enable", v[1:0], 0);
    repeat (10) @(negedge clk);
    chk(cs_falls == 0, "R4 no cs without enable", cs_falls, 0);
  endtask

  task automatic t_tx_only();
    logic [31:0] v;
    wr(A_MISC, 32'd3); clr_mon();
    wr(A_BUF, 32'h003C_A59F);
    run(3, 0);
    rd(A_CTL, v); chk(v[1:0] == 2'b11, "R5 ready while busy", v[1:0], 2'b11);
    wait_idle("R5 busy clears");
    rd(A_CTL, v); chk(v[1], "R5 ready held after done", v[1], 1);
    chk(mosi_sh[23:0] == 24'h9FA53C, "R2 mosi msb first", mosi_sh[23:0], 24'h9FA53C);
    chk(sck_total == 24, "R2 sck count", sck_total, 24);
    chk(last_low == 48, "R9 cs low time", last_low, 48);
    wr(A_CTL, 0);
    rd(A_CTL, v); chk(v[1] == 1'b0, "R5 ready cleared by zero write", v[1], 0);
  endtask

  task automatic t_txrx();
    logic [31:0] v;
    wr(A_MISC, 32'd2); s_dly = 0; clr_mon();
    s_data[0] = 8'hC3; s_data[1] = 8'h5A; s_data[2] = 8'h81;
    wr(A_BUF, 32'hFFFF_0B03); wr(A_BUF + 7'd1, 32'hFFFF_FFFF);
    run(2, 3); wait_idle("R3 done"); wr(A_CTL, 0);
    rd(A_BUF, v); chk(v == 32'h5AC3_0B03, "R3 reply after output", v, 32'h5AC3_0B03);
    rd(A_BUF + 7'd1, v); chk(v[7:0] == 8'h81, "R3 last reply byte", v[7:0], 8'h81);
    chk(mosi_sh[39:24] == 16'h030B, "R2 output bytes", mosi_sh[39:24], 16'h030B);
    chk(last_low == 80, "R9 cs low covers input", last_low, 80);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    s_dly = 2; s_data[0] = 8'hA5;
    wr(A_BUF, 32'h0000_000B);
    wr(A_MISC, (32'd2 << 8) | 32'd2);
    run(1, 1); wait_idle("R10 done L2"); wr(A_CTL, 0);
    rd(A_BUF, v); chk(v[15:8] == 8'hA5, "R10 latency 2 slow slave", v[15:8], 8'hA5);
    wr(A_MISC, 32'd2);
    run(1, 1); wait_idle("R10 done L0"); wr(A_CTL, 0);
    rd(A_BUF, v); chk(v[15:8] == 8'h52, "R10 latency 0 slips one bit", v[15:8], 8'h52);
    s_dly = 0;
  endtask

  task automatic t_zero();
    logic [31:0] v;
    clr_mon(); run(0, 0); wait_idle("R7 zero done");
    rd(A_CTL, v); chk(v[1] == 1'b1, "R7 ready set", v[1], 1);
    chk(cs_falls == 0, "R7 no chip select", cs_falls, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_busy_trig();
    clr_mon(); run(4, 0);
    repeat (10) @(negedge clk);
    wr(A_OLEN, 1); wr(A_CTL, GO);
    wait_idle("R6 done");
    chk(cs_falls == 1, "R6 single transaction", cs_falls, 1);
    chk(sck_total == 32, "R6 length unchanged", sck_total, 32);
    wr(A_CTL, 0);
  endtask

  task automatic t_oversize();
    logic [31:0] v;
    clr_mon(); run(100, 29);
    rd(A_CTL, v); chk(v[0] == 1'b0, "R8 oversize ignored", v[0], 0);
    repeat (20) @(negedge clk);
    chk(cs_falls == 0, "R8 no chip select", cs_falls, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_desel();
    wr(A_MISC, 32'd20); clr_mon();
    run(1, 0); wait_idle("R9 first");
    wr(A_CTL, 0); wr(A_CTL, GO);
    wait_idle("R9 second");
    chk(cs_falls == 2, "R9 two transactions", cs_falls, 2);
    chk(last_gap >= 20 && last_gap <= 22, "R9 deselect gap", last_gap, 21);
    wr(A_CTL, 0);
  endtask

  task automatic t_softrst();
    logic [31:0] v;
    wr(A_MISC, 32'd2); run(16, 0);
    repeat (20) @(negedge clk);
    wr(A_MISC, 32'h1000_0002);
    rd(A_STAT, v); chk(v[3:0] == 4'd0, "R11 state idle in reset", v[3:0], 0);
    rd(A_CTL, v);  chk(v[1:0] == 2'b00, "R11 ready busy cleared", v[1:0], 0);
    chk(spi_cs_n === 1'b1, "R11 cs released", spi_cs_n, 1);
    wr(A_MISC, 32'd2);
    clr_mon(); run(1, 0); wait_idle("R11 works after reset");
    chk(sck_total == 8, "R11 engine usable after reset", sck_total, 8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset(); t_buffer(); t_misc(); t_trig_noen(); t_tx_only(); t_txrx();
    t_latency(); t_zero(); t_busy_trig(); t_oversize(); t_desel(); t_softrst();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule